// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave for a Stereo Noise-Cancelling Audio Core

This block receives configuration over a two-wire I2C bus and holds the control state for a stereo audio processing core. The bus lines are sampled with the fast system clock. Each line passes through a two-flop synchroniser and a three-tap majority vote, and bus conditions are then decoded from the cleaned levels. The slave answers to a single fixed address. After the address byte, the next byte is a register pointer and the byte after that is the value for that register. The slave acknowledges bytes by pulling SDA low through an open-drain enable. Written values are only staged while the transfer runs. They reach the register file when a STOP arrives.

The register file has five entries. Four of them are 5-bit gain codes: one cancelling gain and one listen-through gain for each of the two channels. The fifth holds three mode bits. The bus never returns data. A read-addressed byte is still acknowledged, but after that the slave leaves SDA alone.

When SCL stays low for a long time, the block drops the serial interface and enters a strapped hardware mode. In that mode SDA becomes a three-level mode selector (low, floating or high). The gains are then forced to their power-on code.

Top module: `hs_cfg_slave`

## Requirements
- R1: After reset all four gain outputs read 0x0B, `run_o`, `anc_off_o` and `ptl_on_o` are 0, `hw_mode_o` is 0 and `sda_pull_o` is 0.
- R2: An address byte of 0x40 (7-bit address 0x20 in bits 7..1, R/W in bit 0, sent MSB first) is acknowledged by asserting `sda_pull_o` during the ninth clock. Any other address is not acknowledged, and the bytes that follow it are neither acknowledged nor stored.
- R3: An address byte of 0x41 (R/W = 1) is acknowledged. After that, `sda_pull_o` stays low until the next START, and no register changes.
- R4: A write consists of the address 0x40, a pointer byte and a data byte, each acknowledged. Pointer 0 sets `anc_gain_l_o`, pointer 1 sets `anc_gain_r_o`, pointer 2 sets `ptl_gain_l_o` and pointer 3 sets `ptl_gain_r_o`. Pointer 4 sets the mode bits: data bit 0 drives `run_o`, bit 1 drives `anc_off_o` and bit 2 drives `ptl_on_o`.
- R5: Written data reaches the outputs only when a STOP arrives. A repeated START keeps the staged value, and the next STOP commits it.
- R6: A pointer above 4 is acknowledged and so is its data byte, but no output changes.
- R7: Gain registers keep only data bits 4..0. A code above 0x17 is stored as 0x17, and bits 7..5 are ignored.
- R8: A STOP that occurs in the same SCL high pulse as a START is ignored. Staged data is then committed at the next STOP.
- R9: A single-sample spike on SDA while SCL is high is ignored and does not disturb the transfer in progress.
- R10: When SCL stays low for `HW_LOW_CYCLES` samples, `hw_mode_o` rises, all gains read 0x0B and `run_o` is 1, and `sda_pull_o` stays low. The mode pins then follow SDA: SDA low gives `ptl_on_o`=1 and `anc_off_o`=0; SDA floating (`sda_float_i`=1) gives both 0; SDA high gives `anc_off_o`=1 and `ptl_on_o`=0. When SCL goes high again, the stored register values return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_float_i | input | 1 | Pad detector: SDA is undriven (used in hardware mode) |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| anc_gain_l_o | output | GAIN_W | Left cancelling gain code |
| anc_gain_r_o | output | GAIN_W | Right cancelling gain code |
| ptl_gain_l_o | output | GAIN_W | Left listen-through gain code |
| ptl_gain_r_o | output | GAIN_W | Right listen-through gain code |
| run_o | output | 1 | 1 = playing, 0 = shut down |
| anc_off_o | output | 1 | 1 = cancelling off, microphone muted |
| ptl_on_o | output | 1 | 1 = microphone routed to output, line attenuated |
| hw_mode_o | output | 1 | Strapped hardware mode active |

## Verification
The bench builds the block with `HW_LOW_CYCLES` reduced to 200 and every other parameter at its default. The reduced timeout lets the bench reach hardware mode and leave it again within a short run. It also stays well above the 20-sample SCL low phase of each bit, so normal transfers can never trip hardware mode by accident. With the default three-tap vote, a one-cycle spike is the widest glitch that must be rejected, and the spike test injects exactly that.

// File: rtl/hscfg_pkg.sv
package hscfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/hscfg_filter.sv
module hscfg_filter #(
  parameter int               LANES       = 3,
  parameter int               SYNC_STAGES = 2,
  parameter int               VOTE_TAPS   = 3,
  parameter logic [LANES-1:0] IDLE_VAL    = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] clean_o
);
  localparam int HALF = VOTE_TAPS / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   tap_q;
    logic                   out_q;
    logic                   vote_d;

    always_comb vote_d = ($countones(tap_q) > HALF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= {SYNC_STAGES{IDLE_VAL[g]}};
        tap_q  <= {VOTE_TAPS{IDLE_VAL[g]}};
        out_q  <= IDLE_VAL[g];
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        out_q  <= vote_d;
      end
    end

    assign clean_o[g] = out_q;
  end
endmodule

// File: rtl/hscfg_cond.sv
module hscfg_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q, in_start_pulse_q, in_start_pulse_d;
  logic raw_start, raw_stop;

  always_comb begin
    raw_start = scl_i & scl_q & sda_q & ~sda_i;
    raw_stop  = scl_i & scl_q & ~sda_q & sda_i;
    rise_o    = scl_i & ~scl_q;
    fall_o    = ~scl_i & scl_q;
    start_o   = raw_start;
    stop_o    = raw_stop & ~in_start_pulse_q;
    in_start_pulse_d = in_start_pulse_q;
    if (raw_start)   in_start_pulse_d = 1'b1;
    else if (fall_o) in_start_pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q            <= 1'b1;
      sda_q            <= 1'b1;
      in_start_pulse_q <= 1'b0;
    end else begin
      scl_q            <= scl_i;
      sda_q            <= sda_i;
      in_start_pulse_q <= in_start_pulse_d;
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o}));  // R8
  AST_STOP_HELD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && scl_i) |=> !stop_o);  // R8
endmodule

// File: rtl/hscfg_engine.sv
module hscfg_engine
  import hscfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int         NUM_REGS = 5,
  parameter int         PTR_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 hw_mode_i,
  output logic                 sda_pull_o,
  output logic                 commit_o,
  output logic [PTR_W-1:0]     wr_ptr_o,
  output logic [BYTE_BITS-1:0] wr_data_o
);
  phase_t               phase_q, phase_d;
  logic [3:0]           cnt_q, cnt_d;
  logic [BYTE_BITS-1:0] shift_q, shift_d, ptr_q, ptr_d, stg_x_q, stg_x_d;
  logic [PTR_W-1:0]     stg_p_q, stg_p_d;
  logic                 stg_v_q, stg_v_d, ack_q, ack_d, commit_q, commit_d;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    ptr_d    = ptr_q;
    ack_d    = ack_q;
    stg_v_d  = stg_v_q;
    stg_p_d  = stg_p_q;
    stg_x_d  = stg_x_q;
    commit_d = 1'b0;
    if (hw_mode_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_i) begin
      phase_d  = PH_IDLE;
      cnt_d    = '0;
      ack_d    = 1'b0;
      commit_d = stg_v_q;
      stg_v_d  = 1'b0;
    end else if (start_i) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (rise_i && cnt_q < 4'd8) begin
        shift_d = {shift_q[BYTE_BITS-2:0], sda_i};
        cnt_d   = cnt_q + 4'd1;
      end else if (fall_i && cnt_q == 4'd8) begin
        cnt_d = 4'd9;
        case (phase_q)
          PH_ADDR: begin
            if (shift_q[7:1] == DEV_ADDR) begin
              ack_d   = 1'b1;
              phase_d = shift_q[0] ? PH_SKIP : PH_PTR;
            end else begin
              phase_d = PH_SKIP;
            end
          end
          PH_PTR: begin
            ack_d   = 1'b1;
            ptr_d   = shift_q;
            phase_d = PH_DATA;
          end
          PH_DATA: begin
            ack_d = 1'b1;
            if (ptr_q < 8'(NUM_REGS)) begin
              stg_v_d = 1'b1;
              stg_p_d = ptr_q[PTR_W-1:0];
              stg_x_d = shift_q;
            end
            phase_d = PH_SKIP;
          end
          default: ;
        endcase
      end else if (fall_i && cnt_q == 4'd9) begin
        cnt_d = '0;
        ack_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      ptr_q    <= '0;
      ack_q    <= 1'b0;
      stg_v_q  <= 1'b0;
      stg_p_q  <= '0;
      stg_x_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      ptr_q    <= ptr_d;
      ack_q    <= ack_d;
      stg_v_q  <= stg_v_d;
      stg_p_q  <= stg_p_d;
      stg_x_q  <= stg_x_d;
      commit_q <= commit_d;
    end
  end

  assign sda_pull_o = ack_q;
  assign commit_o   = commit_q;
  assign wr_ptr_o   = stg_p_q;
  assign wr_data_o  = stg_x_q;

  AST_ACK_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_q) |-> !scl_i);  // R2
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(stop_i));  // R5
  AST_HW_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode_i |=> !ack_q);  // R10
  AST_READ_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP && cnt_q < 4'd8) |-> !ack_q);  // R3
endmodule

// File: rtl/hscfg_regs.sv
module hscfg_regs #(
  parameter int   NUM_REGS  = 5,
  parameter int   PTR_W     = $clog2(NUM_REGS),
  parameter int   GAIN_W    = 5,
  parameter int   GAIN_MAX  = 23,
  parameter int   GAIN_POR  = 11,
  parameter int   MODE_BITS = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit_i,
  input  logic [PTR_W-1:0]                   ptr_i,
  input  logic [7:0]                         data_i,
  output logic [NUM_REGS-2:0][GAIN_W-1:0]    gain_o,
  output logic [MODE_BITS-1:0]               mode_o
);
  localparam int NUM_GAINS = NUM_REGS - 1;

  logic [GAIN_W-1:0] clamped;
  logic              unused_hi;

  always_comb begin
    clamped = (data_i[GAIN_W-1:0] > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : data_i[GAIN_W-1:0];
  end
  assign unused_hi = ^data_i[7:GAIN_W];

  for (genvar i = 0; i < NUM_GAINS; i++) begin : g_gain
    logic              we;
    logic [GAIN_W-1:0] gain_q;
    always_comb we = commit_i && (ptr_i == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gain_q <= GAIN_W'(GAIN_POR);
      else if (we) gain_q <= clamped;
    end
    assign gain_o[i] = gain_q;

    AST_GAIN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      gain_q <= GAIN_W'(GAIN_MAX));  // R7
  end

  logic                 mode_we;
  logic [MODE_BITS-1:0] mode_q;
  always_comb mode_we = commit_i && (ptr_i == PTR_W'(NUM_GAINS));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= data_i[MODE_BITS-1:0];
  end
  assign mode_o = mode_q;

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(gain_o) && $stable(mode_q)));  // R5
endmodule

// File: rtl/hs_cfg_slave.sv
module hs_cfg_slave #(
  parameter logic [6:0] DEV_ADDR      = 7'h20,
  parameter int         GAIN_W        = 5,
  parameter int         GAIN_MAX      = 23,
  parameter int         GAIN_POR      = 11,
  parameter int         SYNC_STAGES   = 2,
  parameter int         VOTE_TAPS     = 3,
  parameter int         HW_LOW_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sda_float_i,
  output logic              sda_pull_o,
  output logic [GAIN_W-1:0] anc_gain_l_o,
  output logic [GAIN_W-1:0] anc_gain_r_o,
  output logic [GAIN_W-1:0] ptl_gain_l_o,
  output logic [GAIN_W-1:0] ptl_gain_r_o,
  output logic              run_o,
  output logic              anc_off_o,
  output logic              ptl_on_o,
  output logic              hw_mode_o
);
  import hscfg_pkg::*;

  localparam int NUM_REGS = 5;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int CW       = $clog2(HW_LOW_CYCLES + 1);

  logic [2:0] clean;
  logic       scl_c, sda_c, float_c;
  logic       start, stop, rise, fall;
  logic       commit, pull;
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       wr_data;
  logic [NUM_REGS-2:0][GAIN_W-1:0] gains;
  logic [2:0]       mode;

  hscfg_filter #(
    .LANES(3), .SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS), .IDLE_VAL(3'b011)
  ) u_filter (
    .clk(clk), .rst_n(rst_n),
    .raw_i({sda_float_i, sda_i, scl_i}),
    .clean_o(clean)
  );
  assign scl_c   = clean[0];
  assign sda_c   = clean[1];
  assign float_c = clean[2];

  hscfg_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_c),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  // Strap-mode detection: SCL held low long enough
  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          hw_q, hw_d;

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (scl_c)                              low_cnt_d = '0;
    else if (low_cnt_q != CW'(HW_LOW_CYCLES)) low_cnt_d = low_cnt_q + CW'(1);
    hw_d = !scl_c && (low_cnt_q == CW'(HW_LOW_CYCLES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      hw_q      <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      hw_q      <= hw_d;
    end
  end

  hscfg_engine #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_c),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .hw_mode_i(hw_q), .sda_pull_o(pull), .commit_o(commit),
    .wr_ptr_o(wr_ptr), .wr_data_o(wr_data)
  );

  hscfg_regs #(
    .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .GAIN_W(GAIN_W),
    .GAIN_MAX(GAIN_MAX), .GAIN_POR(GAIN_POR), .MODE_BITS(3)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .ptr_i(wr_ptr),
    .data_i(wr_data), .gain_o(gains), .mode_o(mode)
  );

  always_comb begin
    sda_pull_o = pull & ~hw_q;
    hw_mode_o  = hw_q;
    if (hw_q) begin
      anc_gain_l_o = GAIN_W'(GAIN_POR);
      anc_gain_r_o = GAIN_W'(GAIN_POR);
      ptl_gain_l_o = GAIN_W'(GAIN_POR);
      ptl_gain_r_o = GAIN_W'(GAIN_POR);
      run_o        = 1'b1;
      anc_off_o    = !float_c && sda_c;
      ptl_on_o     = !float_c && !sda_c;
    end else begin
      anc_gain_l_o = gains[0];
      anc_gain_r_o = gains[1];
      ptl_gain_l_o = gains[2];
      ptl_gain_r_o = gains[3];
      run_o        = mode[0];
      anc_off_o    = mode[1];
      ptl_on_o     = mode[2];
    end
  end

  AST_HW_NEEDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hw_q |-> !$past(scl_c));  // R10
endmodule

// File: tb/hs_cfg_slave_test.sv
`timescale 1ns/1ps
module hs_cfg_slave_test;
  localparam int Q   = 10;
  localparam int HWC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, glitch = 1'b0, flt = 1'b0;
  logic sda_w;
  logic pull;
  logic [4:0] ga_l, ga_r, gp_l, gp_r;
  logic run, aoff, pon, hw;

  int n_chk = 0, n_err = 0;
  logic [4:0] e_gain [4];
  logic [2:0] e_mode;

  always #10 clk = ~clk;

  assign sda_w = (m_sda & ~pull) ^ glitch;

  hs_cfg_slave #(.HW_LOW_CYCLES(HWC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_float_i(flt),
    .sda_pull_o(pull), .anc_gain_l_o(ga_l), .anc_gain_r_o(ga_r),
    .ptl_gain_l_o(gp_l), .ptl_gain_r_o(gp_r), .run_o(run),
    .anc_off_o(aoff), .ptl_on_o(pon), .hw_mode_o(hw)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "anc_gain_l", int'(ga_l), int'(e_gain[0]));
    chk(req, "anc_gain_r", int'(ga_r), int'(e_gain[1]));
    chk(req, "ptl_gain_l", int'(gp_l), int'(e_gain[2]));
    chk(req, "ptl_gain_r", int'(gp_r), int'(e_gain[3]));
    chk(req, "run", int'(run), int'(e_mode[0]));
    chk(req, "anc_off", int'(aoff), int'(e_mode[1]));
    chk(req, "ptl_on", int'(pon), int'(e_mode[2]));
  endtask

  task automatic bus_start;
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_at, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); scl = 1'b1;
      if (i == glitch_at) begin
        repeat (4) @(negedge clk);
        glitch = 1'b1; @(negedge clk); glitch = 1'b0;
        repeat (2 * Q - 5) @(negedge clk);
      end else begin
        qw(2);
      end
      scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); acked = pull; qw(); scl = 1'b0; qw();
  endtask

  task automatic write_frame(input logic [7:0] ptr, input logic [7:0] dat,
                             input string req, input bit do_stop);
    logic a;
    bus_start;
    send_byte(8'h40, -1, a); chk(req, "addr ack", int'(a), 1);
    send_byte(ptr, -1, a);   chk(req, "ptr ack", int'(a), 1);
    send_byte(dat, -1, a);   chk(req, "data ack", int'(a), 1);
    if (do_stop) bus_stop;
  endtask

  function automatic logic [4:0] clampv(input logic [7:0] d);
    return (d[4:0] > 5'd23) ? 5'd23 : d[4:0];
  endfunction

  task automatic t_reset;
    chk("R1", "sda_pull", int'(pull), 0);
    chk("R1", "hw_mode", int'(hw), 0);
    check_all("R1");
  endtask

  task automatic t_basic_write;
    write_frame(8'h00, 8'h05, "R4", 1'b0);
    check_all("R5");
    bus_stop;
    e_gain[0] = 5'h05;
    check_all("R4");
  endtask

  task automatic t_all_regs;
    write_frame(8'h01, 8'h10, "R4", 1'b1); e_gain[1] = 5'h10;
    write_frame(8'h02, 8'h00, "R4", 1'b1); e_gain[2] = 5'h00;
    write_frame(8'h03, 8'h17, "R4", 1'b1); e_gain[3] = 5'h17;
    write_frame(8'h04, 8'h07, "R4", 1'b1); e_mode = 3'b111;
    check_all("R4");
    write_frame(8'h04, 8'h03, "R4", 1'b1); e_mode = 3'b011;
    check_all("R4");
  endtask

  task automatic t_clamp;
    write_frame(8'h00, 8'h1F, "R7", 1'b1); e_gain[0] = clampv(8'h1F);
    write_frame(8'h01, 8'hE4, "R7", 1'b1); e_gain[1] = clampv(8'hE4);
    chk("R7", "clamped gain", int'(ga_l), 23);
    chk("R7", "upper bits dropped", int'(ga_r), 4);
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start;
    send_byte(8'h42, -1, a); chk("R2", "foreign addr ack", int'(a), 0);
    send_byte(8'h00, -1, a); chk("R2", "after foreign ack", int'(a), 0);
    send_byte(8'h09, -1, a); chk("R2", "after foreign ack", int'(a), 0);
    bus_stop;
    check_all("R2");
  endtask

  task automatic t_read_addr;
    logic a;
    int seen = 0;
    bus_start;
    send_byte(8'h41, -1, a); chk("R3", "read addr ack", int'(a), 1);
    m_sda = 1'b1;
    for (int k = 0; k < 9; k++) begin
      qw(); scl = 1'b1; qw(); if (pull) seen++; qw(); scl = 1'b0; qw();
    end
    chk("R3", "pull during read bytes", seen, 0);
    bus_stop;
    check_all("R3");
  endtask

  task automatic t_bad_ptr;
    write_frame(8'h07, 8'h02, "R6", 1'b1);
    check_all("R6");
  endtask

  task automatic t_rep_start;
    logic a;
    write_frame(8'h02, 8'h09, "R5", 1'b0);
    bus_start;
    send_byte(8'h41, -1, a); chk("R5", "addr ack after Sr", int'(a), 1);
    check_all("R5");
    bus_stop;
    e_gain[2] = 5'h09;
    check_all("R5");
  endtask

  task automatic t_same_pulse;
    write_frame(8'h00, 8'h02, "R8", 1'b0);
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_sda = 1'b1; qw();
    scl = 1'b0; qw();
    check_all("R8");
    bus_stop;
    e_gain[0] = 5'h02;
    check_all("R8");
  endtask

  task automatic t_glitch;
    logic a;
    bus_start;
    send_byte(8'h40, -1, a); chk("R9", "addr ack", int'(a), 1);
    send_byte(8'h01, -1, a); chk("R9", "ptr ack", int'(a), 1);
    send_byte(8'h86, 7, a);  chk("R9", "data ack with spike", int'(a), 1);
    bus_stop;
    e_gain[1] = 5'h06;
    check_all("R9");
  endtask

  task automatic t_hw_mode;
    scl = 1'b0; qw(); m_sda = 1'b0;
    repeat (HWC + 20) @(negedge clk);
    chk("R10", "hw_mode", int'(hw), 1);
    chk("R10", "sda_pull", int'(pull), 0);
    chk("R10", "gain", int'(ga_l), 11);
    chk("R10", "gain", int'(gp_r), 11);
    chk("R10", "run", int'(run), 1);
    chk("R10", "low: ptl_on", int'(pon), 1);
    chk("R10", "low: anc_off", int'(aoff), 0);
    m_sda = 1'b1; qw(2);
    chk("R10", "high: anc_off", int'(aoff), 1);
    chk("R10", "high: ptl_on", int'(pon), 0);
    flt = 1'b1; qw(2);
    chk("R10", "float: anc_off", int'(aoff), 0);
    chk("R10", "float: ptl_on", int'(pon), 0);
    chk("R10", "float: run", int'(run), 1);
    flt = 1'b0; qw(); scl = 1'b1; qw(2);
    chk("R10", "hw_mode exit", int'(hw), 0);
    check_all("R10");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) e_gain[i] = 5'h0B;
    e_mode = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_reset;
    t_basic_write;
    t_all_regs;
    t_clamp;
    t_wrong_addr;
    t_read_addr;
    t_bad_ptr;
    t_rep_start;
    t_same_pulse;
    t_glitch;
    t_hw_mode;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule